// File: doc/BRIEF.md
# DRAM Supply-Current Command Sequencer

This block drives a DDR SDRAM command bus with an endless, fixed-shape loop of commands. It is meant for supply-current characterisation, where the memory has to be kept in one known activity pattern for as long as the measurement runs. One command leaves the block on every clock. It appears on the four active-low command strobes, together with a bank number, an address word and a data pattern for the burst.

Two loop shapes exist. The single-bank loop opens a row in one bank, reads it with burst length 2 and closes it with an explicit precharge. NOP cycles fill the gaps, and the address and bank lines flip on every NOP. The four-bank loop opens rows in banks 0 to 3, two clocks apart, and reads each one three clocks after its activate, with auto-precharge. During its NOPs the buses hold still. A two-bit speed-grade input selects how many NOP cycles pad each loop. Every loop takes a fresh row and column from a 16-bit LFSR. The data pattern flips half of its bits on every read burst.

The `start` input begins the loop. The `stop` input ends it at the next loop boundary. Mode and grade are sampled only at the edge that begins a loop.

Top module: `dram_load_seq`

## Requirements
- R1: Commands are encoded on {ras_n,cas_n,we_n} with cs_n held low: NOP=111, Activate=011, Read=101, Precharge=010. No other code (in particular no Write) is ever driven. After reset the bus shows NOP with addr=0, ba=0 and dpat equal to the low-half-ones value (8'h0F at DQ_W=8).
- R2: A loop starts at a clock edge where start=1 and stop=0. Mode and grade are sampled at that edge, and the next cycle shows Activate. When start and stop are high together, the block stays idle.
- R3: In single-bank mode the loop (slot 0 first, A=Activate, R=Read, P=Precharge, others NOP) is selected by grade as follows: grade 0 has 8 slots with R at 2 and P at 6; grade 1 has 9 slots with R at 3 and P at 6; grade 2 has 10 slots with R at 3 and P at 7; grade 3 has 7 slots with R at 2 and P at 5.
- R4: In single-bank mode every command uses bank 0. A Read drives the column on addr[COL_W-1:0] with addr[10]=0. A Precharge drives addr=0.
- R5: In single-bank mode, each NOP inside a running loop drives addr and ba as the bitwise inverse of the previous cycle's values.
- R6: In four-bank mode at grades 0 to 2, the loop has 10 slots: A0,N,A1,R0,A2,R1,A3,R2,N,R3. The digit is the bank driven on ba. No two Activates are ever adjacent.
- R7: In four-bank mode at grade 3, the loop has 8 slots: A0,x,A1,R0,A2,R1,A3,R2. Slot x is R3 of the previous loop when that loop was also four-bank grade 3, and NOP otherwise.
- R8: In four-bank mode every Read has addr[10]=1, which requests auto-precharge. No Precharge command is issued.
- R9: In four-bank mode, on NOP cycles, during drain and while idle, addr and ba keep their previous values.
- R10: A 16-bit LFSR (seed 16'hACE1, next = {l[14:0], l[15]^l[14]^l[12]^l[3]}) steps once at every loop start. Activate drives addr = l[ADDR_W-1:0] and a Read column is l[15 -: COL_W].
- R11: dpat inverts its upper DQ_W/2 bits in the cycle after each Read and is otherwise unchanged, so consecutive bursts differ in exactly half of their bits.
- R12: A change of mode or grade in the middle of a loop does not alter that loop. The next loop follows the new setting.
- R13: A stop ends the run after the current loop, after which NOP is driven. If a four-bank grade-3 loop ends without a grade-3 successor, a two-cycle drain (NOP, then R3 on bank 3) precedes the idle state or the next loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin looping |
| stop | input | 1 | Halt after the current loop |
| four_bank | input | 1 | 1 = four-bank interleave, 0 = single bank |
| grade | input | 2 | Speed-grade select |
| cs_n | output | 1 | Chip select, held low |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable strobe |
| ba | output | BA_W | Bank number |
| addr | output | ADDR_W | Row, column or precharge address |
| dpat | output | DQ_W | Burst data pattern |

## Verification
The command outputs decode combinationally from registered loop state. An input sampled at one rising edge therefore shows its effect in the cycle that follows that edge: the first Activate after `start`, the first loop under a new grade, and the drain or idle NOP after `stop`. The dpat change comes one cycle after the Read that causes it. The bench drives inputs and samples outputs on falling edges, so each check sees the cycle that follows the edge at which its stimulus was captured. Expected addresses come from a model of the LFSR and of the previous cycle's bus, and they are walked in step with the same slot count.

// File: rtl/dram_load_seq.sv
module dram_load_seq #(
  parameter int ADDR_W = 13,
  parameter int COL_W = 10,
  parameter int BA_W = 2,
  parameter int DQ_W = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              four_bank,
  input  logic [1:0]        grade,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dpat
);
  localparam logic [DQ_W-1:0] LO_MASK = {{(DQ_W - DQ_W/2){1'b0}}, {(DQ_W/2){1'b1}}};
  localparam logic [DQ_W-1:0] HI_MASK = ~LO_MASK;
  localparam int AP_BIT = 10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;
  typedef enum logic [1:0] {K_NOP, K_ACT, K_RD, K_PRE} kind_t;

  state_t            state;
  logic [3:0]        slot;
  logic              cfg_fb;
  logic [1:0]        cfg_gr;
  logic              carry;
  logic              keep;
  logic [15:0]       lfsr;
  logic [ADDR_W-1:0] prev_addr;
  logic [BA_W-1:0]   prev_ba;
  logic [DQ_W-1:0]   dp;

  kind_t             kind;
  logic [1:0]        bk;
  logic [3:0]        last_slot;
  logic [3:0]        rd_slot;
  logic [3:0]        pre_slot;
  logic [ADDR_W-1:0] rd_addr;
  logic              go;
  logic              slow4;
  logic              in_run;
  logic              in_drain;
  logic [15:0]       lfsr_nx;

  assign go       = (keep | start) & ~stop;
  assign slow4    = cfg_fb & (cfg_gr == 2'd3);
  assign in_run   = (state == S_RUN);
  assign in_drain = (state == S_DRAIN);
  assign lfsr_nx  = {lfsr[14:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};

  always_comb begin
    case (cfg_gr)
      2'd0: begin rd_slot = 4'd2; pre_slot = 4'd6; last_slot = 4'd7; end
      2'd1: begin rd_slot = 4'd3; pre_slot = 4'd6; last_slot = 4'd8; end
      2'd2: begin rd_slot = 4'd3; pre_slot = 4'd7; last_slot = 4'd9; end
      default: begin rd_slot = 4'd2; pre_slot = 4'd5; last_slot = 4'd6; end
    endcase
    if (cfg_fb) last_slot = slow4 ? 4'd7 : 4'd9;
  end

  always_comb begin
    kind = K_NOP;
    bk   = 2'd0;
    if (in_run && !cfg_fb) begin
      if (slot == 4'd0) kind = K_ACT;
      else if (slot == rd_slot) kind = K_RD;
      else if (slot == pre_slot) kind = K_PRE;
    end else if (in_run) begin
      case (slot)
        4'd0: begin kind = K_ACT; bk = 2'd0; end
        4'd1: if (slow4 && carry) begin kind = K_RD; bk = 2'd3; end
        4'd2: begin kind = K_ACT; bk = 2'd1; end
        4'd3: begin kind = K_RD;  bk = 2'd0; end
        4'd4: begin kind = K_ACT; bk = 2'd2; end
        4'd5: begin kind = K_RD;  bk = 2'd1; end
        4'd6: begin kind = K_ACT; bk = 2'd3; end
        4'd7: begin kind = K_RD;  bk = 2'd2; end
        4'd9: if (!slow4) begin kind = K_RD; bk = 2'd3; end
        default: ;
      endcase
    end else if (in_drain && slot == 4'd1) begin
      kind = K_RD;
      bk   = 2'd3;
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:0] = lfsr[15 -: COL_W];
    rd_addr[AP_BIT] = cfg_fb;
  end

  always_comb begin
    case (kind)
      K_ACT: begin addr = lfsr[ADDR_W-1:0]; ba = BA_W'(bk); end
      K_RD:  begin addr = rd_addr;           ba = BA_W'(bk); end
      K_PRE: begin addr = '0;                ba = BA_W'(bk); end
      default: begin
        if (in_run && !cfg_fb) begin
          addr = ~prev_addr;
          ba   = ~prev_ba;
        end else begin
          addr = prev_addr;
          ba   = prev_ba;
        end
      end
    endcase
  end

  assign cs_n  = 1'b0;
  assign ras_n = ~(kind == K_ACT || kind == K_PRE);
  assign cas_n = ~(kind == K_RD);
  assign we_n  = ~(kind == K_PRE);
  assign dpat  = dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_ba   <= '0;
      dp        <= LO_MASK;
    end else begin
      prev_addr <= addr;
      prev_ba   <= ba;
      if (kind == K_RD) dp <= dp ^ HI_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      slot   <= '0;
      cfg_fb <= 1'b0;
      cfg_gr <= '0;
      carry  <= 1'b0;
      keep   <= 1'b0;
      lfsr   <= LFSR_SEED;
    end else begin
      keep <= go;
      case (state)
        S_IDLE: if (go) begin
          state  <= S_RUN;
          slot   <= '0;
          cfg_fb <= four_bank;
          cfg_gr <= grade;
          carry  <= 1'b0;
          lfsr   <= lfsr_nx;
        end
        S_RUN: begin
          if (slot != last_slot) begin
            slot <= slot + 4'd1;
          end else if (slow4 && go && four_bank && grade == 2'd3) begin
            slot  <= '0;
            carry <= 1'b1;
            lfsr  <= lfsr_nx;
          end else if (slow4) begin
            state <= S_DRAIN;
            slot  <= '0;
          end else if (go) begin
            slot   <= '0;
            cfg_fb <= four_bank;
            cfg_gr <= grade;
            carry  <= 1'b0;
            lfsr   <= lfsr_nx;
          end else begin
            state <= S_IDLE;
            slot  <= '0;
          end
        end
        S_DRAIN: begin
          if (slot == 4'd0) begin
            slot <= 4'd1;
          end else if (go) begin
            state  <= S_RUN;
            slot   <= '0;
            cfg_fb <= four_bank;
            cfg_gr <= grade;
            carry  <= 1'b0;
            lfsr   <= lfsr_nx;
          end else begin
            state <= S_IDLE;
            slot  <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dram_load_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W = 2,
  parameter int DQ_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQ_W-1:0]   dpat,
  input logic              in_run,
  input logic              in_drain,
  input logic              cfg_fb,
  input logic [1:0]        cfg_gr,
  input logic [3:0]        slot
);
  logic act, rd, pre, nop;
  assign act = ~ras_n & cas_n & we_n;
  assign rd  = ras_n & ~cas_n & we_n;
  assign pre = ~ras_n & cas_n & ~we_n;
  assign nop = ras_n & cas_n & we_n;

  assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && (act || rd || pre || nop));

  assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> !act);

  assert_sb_read_no_ap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !cfg_fb && rd) |-> !addr[10]);

  assert_fb_read_ap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fb && rd) |-> addr[10]);

  assert_fb_no_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fb |-> !pre);

  assert_sb_nop_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !cfg_fb && nop) |-> (addr == ~$past(addr) && ba == ~$past(ba)));

  assert_fb_nop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_run || in_drain) && cfg_fb && nop) |-> ($stable(addr) && $stable(ba)));

  assert_dpat_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ($countones(dpat ^ $past(dpat)) == DQ_W/2));

  assert_dpat_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(dpat));

  assert_cfg_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && slot != 4'd0) |-> $stable({cfg_fb, cfg_gr}));

  assert_idle_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !in_drain) |-> (nop && $stable(addr) && $stable(ba)));
endmodule

bind dram_load_seq dram_load_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .dpat(dpat), .in_run(in_run), .in_drain(in_drain),
  .cfg_fb(cfg_fb), .cfg_gr(cfg_gr), .slot(slot)
);

// File: tb/dram_load_seq_test.sv
module dram_load_seq_test;
  localparam int ADDR_W = 13;
  localparam int COL_W = 10;
  localparam int BA_W = 2;
  localparam int DQ_W = 8;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, four_bank = 1'b0;
  logic [1:0] grade = 2'd0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0] dpat;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] lf;
  logic [ADDR_W-1:0] pa;
  logic [BA_W-1:0] pb;
  logic [DQ_W-1:0] dp;

  always #2 clk = ~clk;

  dram_load_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BA_W(BA_W), .DQ_W(DQ_W), .LFSR_SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .four_bank(four_bank), .grade(grade),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dpat(dpat));

  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction

  function automatic int loop_len(input bit m, input logic [1:0] g);
    if (m) return (g == 2'd3) ? 8 : 10;
    case (g)
      2'd0: return 8;
      2'd1: return 9;
      2'd2: return 10;
      default: return 7;
    endcase
  endfunction

  // returns {kind, bank}; kind 0=NOP 1=ACT 2=READ 3=PRE
  function automatic logic [3:0] slot_cmd(input bit m, input logic [1:0] g, input int s, input bit cr);
    int r, p;
    if (!m) begin
      r = (g == 2'd1 || g == 2'd2) ? 3 : 2;
      p = (g == 2'd2) ? 7 : (g == 2'd3) ? 5 : 6;
      if (s == 0) return 4'b0100;
      if (s == r) return 4'b1000;
      if (s == p) return 4'b1100;
      return 4'b0000;
    end
    case (s)
      0: return 4'b0100;
      1: return (g == 2'd3 && cr) ? 4'b1011 : 4'b0000;
      2: return 4'b0101;
      3: return 4'b1000;
      4: return 4'b0110;
      5: return 4'b1001;
      6: return 4'b0111;
      7: return 4'b1010;
      9: return 4'b1011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(input int kind, input int bk, input bit inv, input bit ap,
                             input string ptag, input string atag, input string ntag);
    logic [2:0] ep;
    logic [ADDR_W-1:0] ea;
    logic [BA_W-1:0] eb;
    case (kind)
      1: ep = 3'b011;
      2: ep = 3'b101;
      3: ep = 3'b010;
      default: ep = 3'b111;
    endcase
    chk(cs_n == 1'b0 && {ras_n, cas_n, we_n} == ep, ptag, "command", {cs_n, ras_n, cas_n, we_n}, {1'b0, ep});
    eb = BA_W'(bk);
    case (kind)
      1: ea = lf[ADDR_W-1:0];
      2: begin ea = '0; ea[COL_W-1:0] = lf[15 -: COL_W]; ea[10] = ap; end
      3: ea = '0;
      default: begin ea = inv ? ~pa : pa; eb = inv ? ~pb : pb; end
    endcase
    if (kind == 0) begin
      chk(addr == ea && ba == eb, ntag, "nop address/bank", {ba, addr}, {eb, ea});
    end else if (kind == 1) begin
      chk(addr == ea, "R10", "activate row", addr, ea);
      chk(ba == eb, atag, "activate bank", ba, eb);
    end else begin
      chk(addr == ea && ba == eb, atag, "read/precharge address", {ba, addr}, {eb, ea});
    end
    if (kind == 2) chk(dpat == dp, "R11", "burst data pattern", dpat, dp);
    pa = ea;
    pb = eb;
    if (kind == 2) dp = dp ^ {{(DQ_W/2){1'b1}}, {(DQ_W - DQ_W/2){1'b0}}};
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; four_bank = 1'b0; grade = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lf = SEED; pa = '0; pb = '0; dp = {{(DQ_W - DQ_W/2){1'b0}}, {(DQ_W/2){1'b1}}};
  endtask

  task automatic drain_check();
    check_cycle(0, 0, 1'b0, 1'b1, "R13", "R13", "R9");
    @(negedge clk);
    check_cycle(2, 3, 1'b0, 1'b1, "R13", "R13", "R13");
    @(negedge clk);
  endtask

  task automatic run_seq(input bit m0, input logic [1:0] g0, input bit m1, input logic [1:0] g1,
                         input int nl, input int chg, input string ptag);
    bit cm, pm, cr;
    logic [1:0] cg, pg;
    int ln;
    logic [3:0] e;
    do_reset();
    four_bank = m0; grade = g0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lf = lfsr_step(lf);
    chk({ras_n, cas_n, we_n} == 3'b011, "R2", "first command after start", {ras_n, cas_n, we_n}, 3'b011);
    for (int L = 0; L < nl; L++) begin
      cm = (L >= chg) ? m1 : m0;
      cg = (L >= chg) ? g1 : g0;
      cr = 1'b0;
      if (L > 0) begin
        pm = (L - 1 >= chg) ? m1 : m0;
        pg = (L - 1 >= chg) ? g1 : g0;
        if (pm && pg == 2'd3 && !(cm && cg == 2'd3)) drain_check();
        cr = pm && pg == 2'd3 && cm && cg == 2'd3;
        lf = lfsr_step(lf);
      end
      ln = loop_len(cm, cg);
      for (int s = 0; s < ln; s++) begin
        e = slot_cmd(cm, cg, s, cr);
        check_cycle(int'(e[3:2]), int'(e[1:0]), !cm, cm, ptag, cm ? "R8" : "R4", cm ? "R9" : "R5");
        if (L == chg - 1 && s == 1) begin four_bank = m1; grade = g1; end
        stop = (L == nl - 1 && s == 1);
        @(negedge clk);
      end
    end
    stop = 1'b0;
    cm = (nl - 1 >= chg) ? m1 : m0;
    cg = (nl - 1 >= chg) ? g1 : g0;
    if (cm && cg == 2'd3) drain_check();
    for (int i = 0; i < 3; i++) begin
      check_cycle(0, 0, 1'b0, 1'b0, "R13", "R13", "R13");
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(addr == '0 && ba == '0, "R1", "reset address/bank", {ba, addr}, 0);
    chk(dpat == 8'h0F, "R1", "reset data pattern", dpat, 8'h0F);
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk({ras_n, cas_n, we_n} == 3'b111, "R2", "start with stop stays idle", {ras_n, cas_n, we_n}, 3'b111);
      @(negedge clk);
    end
  endtask

  task automatic t_single(input logic [1:0] g);
    run_seq(1'b0, g, 1'b0, g, 3, 99, "R3");
  endtask

  task automatic t_four(input logic [1:0] g);
    run_seq(1'b1, g, 1'b1, g, 3, 99, (g == 2'd3) ? "R7" : "R6");
  endtask

  task automatic t_grade_change();
    run_seq(1'b0, 2'd0, 1'b0, 2'd2, 3, 1, "R12");
  endtask

  task automatic t_mode_change_drain();
    run_seq(1'b1, 2'd3, 1'b0, 2'd1, 3, 1, "R12");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    for (int g = 0; g < 4; g++) t_single(2'(g));
    t_four(2'd0);
    t_four(2'd2);
    t_four(2'd3);
    t_grade_change();
    t_mode_change_drain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule